// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block collects up to 64 interrupt lines, records each one in a sticky status bit, and raises two request outputs toward a processor: a fast request and a normal request. Every channel has its own enable bit and a 3-bit priority level. Levels 0 and 1 route a channel to the fast request (0 is more urgent). Levels 2 to 7 route it to the normal request (2 is most urgent, 7 least).

For each request output the block picks the most urgent pending channel and forms an entry address: a programmable table base plus the winning channel number times a selectable entry spacing. Software reads this address from a register and jumps to it. Channel 0 is reserved to mean "no interrupt", so an idle group yields the bare table base. A control bit lets the entry lookup count pending channels whether or not they are enabled. A second control bit delays the effect of disabling a channel by one cycle.

Top module: `prio_vec_intc`

## Requirements
- R1: Every cycle, a high level on input line k (k >= 1) sets status bit k, whether or not channel k is enabled; input line 0 never sets a status bit.
- R2: Writing 1 to a status bit clears it and writing 0 leaves it unchanged; if the input line is still high in the same cycle, the bit stays set. Status words sit at addresses 0x00 (channels 0-31) and 0x01 (channels 32-63).
- R3: Enable words sit at 0x04 (channels 0-31) and 0x05 (channels 32-63), reset to 0; bit 0 of word 0x04 always reads 1.
- R4: `fiq_req` is high exactly when some channel with level 0 or 1 has its status and enable bits set; `irq_req` likewise for levels 2-7.
- R5: Within a group, the pending channel with the smaller level value wins; on equal levels the lower channel number wins.
- R6: The fast entry (address 0x0A) and normal entry (0x0B) read base + channel * (4 << SZ), where base is the register at 0x09 and SZ is bits [3:2] of the control register at 0x08; with no candidate the entry reads base.
- R7: Control bit 0 (raw select): when 0 only enabled pending channels compete for the entry; when 1 all pending channels compete. The request outputs always use enabled channels only.
- R8: The entry registers are combinational: the read in the cycle after a status clear already shows the next winner.
- R9: Control bit 1 (delayed disable): when 1, clearing an enable bit removes that channel from requests one cycle later than when the bit is 0.
- R10: Priority word at address 0x10+k holds channels 8k to 8k+7; channel 8k+j uses bits [4j+2:4j], bit 4j+3 reads 0; every level resets to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_CH | Interrupt lines, sampled each cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| fiq_req | output | 1 | Fast interrupt request |
| irq_req | output | 1 | Normal interrupt request |

## Verification
The assertions take for granted that input lines are low while reset is held, so status after reset only reflects lines seen after release, and that the delayed-disable mode bit is not changed in the same cycle as an enable write, since the one-cycle hold is only promised while the mode is steady. The bench raises lines only after reset, pulses them between clock edges, and writes the control register in its own cycle before any enable change it wants to observe.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int DW       = 32;
   localparam int REG_AW   = 5;
   localparam int LVL_W    = 3;
   localparam int NUM_LVL  = 1 << LVL_W;
   localparam int CH_PER_W = DW / 4;

   localparam int STAT_OFS = 0;
   localparam int EN_OFS   = 4;
   localparam int CTRL_OFS = 8;
   localparam int BASE_OFS = 9;
   localparam int FENT_OFS = 10;
   localparam int NENT_OFS = 11;
   localparam int PRIO_OFS = 16;

   localparam int CTRL_RAW = 0;
   localparam int CTRL_DLY = 1;
   localparam int CTRL_SZ  = 2;

   function automatic logic [NUM_LVL-1:0] lvl_range(input int lo, input int hi);
      logic [NUM_LVL-1:0] m;
      m = '0;
      for (int l = 0; l < NUM_LVL; l++)
         if (l >= lo && l <= hi) m[l] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_CH = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         irq_in,
   input  logic                      we,
   input  logic [REG_AW-1:0]         addr,
   input  logic [DW-1:0]             wdata,
   output logic [NUM_CH-1:0]         stat_q,
   output logic [NUM_CH-1:0]         en_q,
   output logic [NUM_CH-1:0]         en_eff,
   output logic                      raw_q,
   output logic                      dly_q,
   output logic [1:0]                size_q,
   output logic [DW-1:0]             base_q,
   output logic [NUM_CH*LVL_W-1:0]   lvl_flat
);
   localparam int NW = NUM_CH / DW;
   localparam int NP = NUM_CH / CH_PER_W;

   logic [NUM_CH-1:0] stat_clr;
   logic [NUM_CH-1:0] en_prev;
   logic              after_rst;

   always_comb begin
      stat_clr = '0;
      for (int w = 0; w < NW; w++)
         if (we && addr == REG_AW'(STAT_OFS + w))
            stat_clr[w*DW +: DW] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q    <= '0;
         en_q      <= '0;
         en_prev   <= '0;
         raw_q     <= 1'b0;
         dly_q     <= 1'b0;
         size_q    <= '0;
         base_q    <= '0;
         lvl_flat  <= '1;
         after_rst <= 1'b0;
      end else begin
         after_rst <= 1'b1;
         stat_q    <= (stat_q & ~stat_clr) | (irq_in & ~NUM_CH'(1));
         en_prev   <= en_q;
         for (int w = 0; w < NW; w++)
            if (we && addr == REG_AW'(EN_OFS + w))
               en_q[w*DW +: DW] <= wdata;
         if (we && addr == REG_AW'(CTRL_OFS)) begin
            raw_q  <= wdata[CTRL_RAW];
            dly_q  <= wdata[CTRL_DLY];
            size_q <= wdata[CTRL_SZ +: 2];
         end
         if (we && addr == REG_AW'(BASE_OFS))
            base_q <= wdata;
         for (int k = 0; k < NP; k++)
            if (we && addr == REG_AW'(PRIO_OFS + k))
               for (int j = 0; j < CH_PER_W; j++)
                  lvl_flat[(k*CH_PER_W + j)*LVL_W +: LVL_W] <= wdata[4*j +: LVL_W];
      end
   end

   assign en_eff = dly_q ? (en_q | en_prev) : en_q;

   // R1: a raised line shows up in status on the next cycle, masked or not
   p_latch_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      after_rst |-> ((stat_q & $past(irq_in) & ~NUM_CH'(1)) == ($past(irq_in) & ~NUM_CH'(1))));

   // R2: write-one clear with the line low empties the bit
   p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == REG_AW'(STAT_OFS) && wdata[1] && !irq_in[1]) |=> !stat_q[1]);

   // R9: in delayed mode a disable still counts for one more cycle
   p_dly_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_q && en_q[1] && we && addr == REG_AW'(EN_OFS) && !wdata[1]) |=> en_eff[1]);
endmodule

// File: rtl/intc_arb.sv
module intc_arb
   import intc_pkg::*;
#(
   parameter int NUM_CH = 64,
   parameter int LVL_LO = 0,
   parameter int LVL_HI = 1,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       cand,
   input  logic [NUM_CH-1:0]       en_pend,
   input  logic [NUM_CH*LVL_W-1:0] lvl_flat,
   output logic                    req,
   output logic                    found,
   output logic [IDX_W-1:0]        win
);
   localparam logic [NUM_LVL-1:0] GRP = lvl_range(LVL_LO, LVL_HI);

   logic [NUM_CH-1:0] in_grp;

   always_comb begin
      for (int i = 0; i < NUM_CH; i++)
         in_grp[i] = GRP[lvl_flat[i*LVL_W +: LVL_W]];
   end

   assign req = |(en_pend & in_grp);

   always_comb begin
      logic [LVL_W-1:0] best;
      logic [LVL_W-1:0] lv;
      found = 1'b0;
      win   = '0;
      best  = '1;
      for (int i = 0; i < NUM_CH; i++) begin
         lv = lvl_flat[i*LVL_W +: LVL_W];
         if (cand[i] && in_grp[i] && (!found || lv < best)) begin
            found = 1'b1;
            best  = lv;
            win   = IDX_W'(i);
         end
      end
   end

   // R5: the winner is a real candidate
   p_win_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> cand[win]);

   // R4: the winner belongs to this group's levels
   p_win_in_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> GRP[lvl_flat[win*LVL_W +: LVL_W]]);

   // R7: an active request always has an entry candidate
   p_req_has_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> found);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import intc_pkg::*;
#(
   parameter int NUM_CH    = 64,
   parameter int FAST_LVLS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] irq_in,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              fiq_req,
   output logic              irq_req
);
   localparam int IDX_W = $clog2(NUM_CH);
   localparam int NW    = NUM_CH / DW;
   localparam int NP    = NUM_CH / CH_PER_W;
   localparam int GRP_LO [2] = '{0, FAST_LVLS};
   localparam int GRP_HI [2] = '{FAST_LVLS - 1, NUM_LVL - 1};

   generate
      if (NUM_CH % DW != 0 || NUM_CH < DW || NUM_CH > 4*DW)
         $error("NUM_CH must be a multiple of 32 between 32 and 128");
      if (FAST_LVLS < 1 || FAST_LVLS >= NUM_LVL)
         $error("FAST_LVLS must leave at least one level in each group");
   endgenerate

   logic [NUM_CH-1:0]       stat_q, en_q, en_eff, en_pend, cand;
   logic                    raw_q, dly_q;
   logic [1:0]              size_q;
   logic [DW-1:0]           base_q;
   logic [NUM_CH*LVL_W-1:0] lvl_flat;
   logic [1:0]              req, found;
   logic [IDX_W-1:0]        win   [2];
   logic [DW-1:0]           entry [2];

   intc_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .we       (bus_we),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .stat_q   (stat_q),
      .en_q     (en_q),
      .en_eff   (en_eff),
      .raw_q    (raw_q),
      .dly_q    (dly_q),
      .size_q   (size_q),
      .base_q   (base_q),
      .lvl_flat (lvl_flat)
   );

   assign en_pend = stat_q & en_eff;
   assign cand    = raw_q ? stat_q : en_pend;

   for (genvar g = 0; g < 2; g++) begin : g_grp
      intc_arb #(
         .NUM_CH (NUM_CH),
         .LVL_LO (GRP_LO[g]),
         .LVL_HI (GRP_HI[g])
      ) u_arb (
         .clk      (clk),
         .rst_n    (rst_n),
         .cand     (cand),
         .en_pend  (en_pend),
         .lvl_flat (lvl_flat),
         .req      (req[g]),
         .found    (found[g]),
         .win      (win[g])
      );
      assign entry[g] = base_q + (DW'(win[g]) << (2 + size_q));
   end

   assign fiq_req = req[0];
   assign irq_req = req[1];

   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < NW; w++) begin
         if (bus_addr == REG_AW'(STAT_OFS + w)) bus_rdata = stat_q[w*DW +: DW];
         if (bus_addr == REG_AW'(EN_OFS + w))
            bus_rdata = en_q[w*DW +: DW] | ((w == 0) ? DW'(1) : DW'(0));
      end
      if (bus_addr == REG_AW'(CTRL_OFS))
         bus_rdata = DW'({size_q, dly_q, raw_q});
      if (bus_addr == REG_AW'(BASE_OFS)) bus_rdata = base_q;
      if (bus_addr == REG_AW'(FENT_OFS)) bus_rdata = entry[0];
      if (bus_addr == REG_AW'(NENT_OFS)) bus_rdata = entry[1];
      for (int k = 0; k < NP; k++)
         if (bus_addr == REG_AW'(PRIO_OFS + k))
            for (int j = 0; j < CH_PER_W; j++)
               bus_rdata[4*j +: 4] = {1'b0, lvl_flat[(k*CH_PER_W + j)*LVL_W +: LVL_W]};
   end

   // R6: an idle group with raw select off yields the bare base
   p_idle_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!raw_q && !fiq_req && !dly_q) |-> !found[0] || en_pend[win[0]]);
endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
   localparam int NCH  = 64;
   localparam int BASE = 32'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NCH-1:0] irq_in = '0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fiq_req, irq_req;

   int n_chk = 0;
   int n_bad = 0;
   int lvl_m [NCH];

   prio_vec_intc #(.NUM_CH(NCH), .FAST_LVLS(2)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fiq_req(fiq_req), .irq_req(irq_req)
   );

   always #10 clk = ~clk;

   // rows: chan A, level A, chan B, level B, expected fast winner, expected normal winner
   localparam int VEC [6][6] = '{
      '{ 5, 0,  9, 3,  5,  9},
      '{12, 1,  3, 1,  3,  0},
      '{40, 2, 20, 6,  0, 40},
      '{63, 4, 33, 4,  0, 33},
      '{ 7, 0,  2, 1,  7,  0},
      '{50, 7, 60, 5,  0, 60}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 5'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse2(input int a, input int b);
      @(negedge clk);
      irq_in[a] = 1'b1; irq_in[b] = 1'b1;
      @(posedge clk); #1;
      irq_in[a] = 1'b0; irq_in[b] = 1'b0;
   endtask

   task automatic set_lvl(input int ch, input int l);
      logic [31:0] w;
      lvl_m[ch] = l;
      w = '0;
      for (int j = 0; j < 8; j++) w[4*j +: 4] = 4'(lvl_m[(ch/8)*8 + j]);
      wr(16 + ch/8, w);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < NCH; i++) lvl_m[i] = 7;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      rd(0, d);  chk("R2 reset status", d, 0);
      rd(4, d);  chk("R3 reset enable, bit0 reads 1", d, 1);
      rd(8, d);  chk("R6 reset control", d, 0);
      rd(10, d); chk("R6 reset fast entry", d, 0);
      rd(17, d); chk("R10 reset levels", d, 32'h77777777);
      chk("R4 reset requests", {30'd0, fiq_req, irq_req}, 0);

      // R10 nibble layout, top bit of each nibble reads 0
      wr(23, 32'h89ABCDEF);
      rd(23, d); chk("R10 priority nibble read", d, 32'h01234567);
      wr(23, 32'h77777777);
      // R3 bit 0 stuck at 1
      wr(4, 0); rd(4, d); chk("R3 channel0 enable reads 1", d, 1);

      wr(9, BASE);
      wr(4, 32'hFFFFFFFF); wr(5, 32'hFFFFFFFF);

      // table walk: R4 R5 R6
      for (int r = 0; r < 6; r++) begin
         int fe, ne;
         set_lvl(VEC[r][0], VEC[r][1]);
         set_lvl(VEC[r][2], VEC[r][3]);
         pulse2(VEC[r][0], VEC[r][2]);
         fe = BASE + VEC[r][4] * 4;
         ne = BASE + VEC[r][5] * 4;
         rd(10, d); chk($sformatf("R5 row%0d fast entry", r), d, fe);
         rd(11, d); chk($sformatf("R5 row%0d normal entry", r), d, ne);
         chk($sformatf("R4 row%0d fast req", r), {31'd0, fiq_req}, (VEC[r][4] != 0) ? 1 : 0);
         chk($sformatf("R4 row%0d normal req", r), {31'd0, irq_req}, (VEC[r][5] != 0) ? 1 : 0);
         wr(0, 32'hFFFFFFFF); wr(1, 32'hFFFFFFFF);
         set_lvl(VEC[r][0], 7);
         set_lvl(VEC[r][2], 7);
      end

      // R1 and R7: masked channel latches; raw select exposes it
      wr(4, 0); wr(5, 0);
      set_lvl(10, 4);
      pulse2(10, 10);
      rd(0, d);  chk("R1 masked status latched", d, 32'h400);
      chk("R7 masked channel gives no request", {31'd0, irq_req}, 0);
      rd(11, d); chk("R7 raw off gives base", d, BASE);
      wr(8, 32'h1);
      rd(11, d); chk("R7 raw on gives masked channel", d, BASE + 40);
      chk("R7 raw on keeps request low", {31'd0, irq_req}, 0);
      wr(8, 0);
      wr(0, 32'hFFFFFFFF);
      rd(0, d);  chk("R2 clear masked status", d, 0);

      // R1 line 0 never sets
      pulse2(0, 0);
      rd(0, d);  chk("R1 line 0 ignored", d, 0);

      // R2 set wins over clear while line high
      @(negedge clk); irq_in[3] = 1'b1;
      wr(0, 32'h8);
      rd(0, d);  chk("R2 held line survives clear", d, 32'h8);
      @(negedge clk); irq_in[3] = 1'b0;
      wr(0, 32'h0);
      rd(0, d);  chk("R2 write zero keeps bit", d, 32'h8);
      wr(0, 32'h8);
      rd(0, d);  chk("R2 clear after line drops", d, 0);

      // R6 entry spacing
      wr(4, 32'hFFFFFFFF); wr(5, 32'hFFFFFFFF);
      set_lvl(21, 2);
      pulse2(21, 21);
      wr(8, 32'h8);
      rd(11, d); chk("R6 spacing 16", d, BASE + 21*16);
      wr(8, 32'hC);
      rd(11, d); chk("R6 spacing 32", d, BASE + 21*32);
      wr(8, 0);

      // R8 immediate update on clear
      set_lvl(30, 5);
      pulse2(30, 30);
      rd(11, d); chk("R8 winner before clear", d, BASE + 21*4);
      wr(0, 32'h1 << 21);
      rd(11, d); chk("R8 next winner right after clear", d, BASE + 30*4);
      wr(0, 32'h1 << 30);
      rd(11, d); chk("R8 idle after last clear", d, BASE);
      chk("R4 normal req drops", {31'd0, irq_req}, 0);

      // R9 delayed disable
      set_lvl(6, 0);
      pulse2(6, 6);
      chk("R4 fast req from level 0", {31'd0, fiq_req}, 1);
      wr(8, 32'h2);
      wr(4, 0);
      chk("R9 delayed disable holds request", {31'd0, fiq_req}, 1);
      @(posedge clk); #1;
      chk("R9 delayed disable drops next cycle", {31'd0, fiq_req}, 0);
      wr(4, 32'hFFFFFFFF);
      wr(8, 0);
      @(posedge clk); #1;
      chk("R9 request back after re-enable", {31'd0, fiq_req}, 1);
      wr(4, 0);
      chk("R9 plain disable acts at once", {31'd0, fiq_req}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule